// File: doc/BRIEF.md
# Packet-to-Bus Transaction Converter

This block sits behind the byte-stream decoder of a serial register-access bridge. It receives one request packet at a time as a stream of bytes, with start and end flags. It reads the header of the packet and carries out 32-bit register writes or reads on a memory-mapped master port that has a wait-request handshake. It then sends a response packet back as a byte stream, with its own start and end flags, toward the encoder.

Each request opens with an 8-byte header. Write requests carry data words after the header. Read requests are only a header. The response shape depends on the command. A write is answered with a short header that reports how many bytes reached the bus. A read is answered with the raw data bytes and no header at all. Unknown codes and the no-operation code get a header with a zero count and never touch the bus.

Top module: `ptt_converter`

## Requirements
- R1: After reset, inReady is 1, and outValid, busRead and busWrite are all 0.
- R2: A request opens with 8 header bytes, and the first of them carries the start flag. Byte 0 is the command code and byte 1 is ignored. Bytes 2..3 are a 16-bit size, most significant byte first. Bytes 4..7 are a 32-bit address, most significant byte first.
- R3: Write codes are 0x00 (fixed address) and 0x04 (sequential). The data bytes after the header are packed into words with the first byte as the least significant. Each complete word causes one bus write. Under 0x04 the address moves up by 4 after each word; under 0x00 it stays the same.
- R4: A write is answered with 4 bytes: the code OR 0x80, then 0x00, then the written byte count most significant byte first. The count is 4 times the number of bus writes. The start flag is on the first byte and the end flag on the last.
- R5: Read codes are 0x10 (fixed address) and 0x14 (sequential). A read issues floor(size/4) bus reads and answers with only the data bytes, each word least significant byte first. The start flag is on the first data byte and the end flag on the last.
- R6: While busWaitReq is high, busRead or busWrite stays asserted, and busAddr and busWdata hold their values. Read data is taken in the cycle where busWaitReq is low.
- R7: Code 0x7F, and any code other than the four above, is answered with {code OR 0x80, 0x00, 0x00, 0x00} and makes no bus access.
- R8: No transfer moves more than 1024 bytes. Write words after the 256th are dropped, so the count stays at 1024. A read size above 1024 is treated as 1024.
- R9: A read whose size is below 4 makes no bus access. It is answered with {code OR 0x80, 0x00, 0x00, 0x00}.
- R10: A packet that ends before its 8th header byte is dropped, with no response and no bus access. Bytes that arrive outside a packet without a start flag are discarded.
- R11: Trailing write bytes that do not fill a whole word are dropped. They are not written and not counted.
- R12: inReady and outValid are never high in the same cycle. While outValid is high and outReady is low, outData and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request byte valid |
| inReady | output | 1 | Block accepts a request byte |
| inData | input | 8 | Request byte |
| inSop | input | 1 | Request byte is the first of a packet |
| inEop | input | 1 | Request byte is the last of a packet |
| outValid | output | 1 | Response byte valid |
| outReady | input | 1 | Downstream accepts the response byte |
| outData | output | 8 | Response byte |
| outSop | output | 1 | First byte of the response |
| outEop | output | 1 | Last byte of the response |
| busAddr | output | 32 | Bus address |
| busRead | output | 1 | Bus read command |
| busWrite | output | 1 | Bus write command |
| busWdata | output | 32 | Bus write data |
| busRdata | input | 32 | Bus read data |
| busWaitReq | input | 1 | Slave stalls the current command |

## Verification
The bench checks data byte order on both paths, so a design with the lanes swapped would write and return words byte-reversed. It checks that fixed-address writes all land on one word and sequential writes step through memory; a design with the step inverted would corrupt neighbouring registers. It drives transfers just over 1 KiB and requests shorter than a header, so a design with no count cap would write a 257th word and report 0x0404, and a design with no drop would answer a broken packet. Random wait-request and output back-pressure expose a master that drops its command during a stall or an encoder that loses bytes.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

  localparam logic [7:0] CODE_WR     = 8'h00;
  localparam logic [7:0] CODE_SEQ_WR = 8'h04;
  localparam logic [7:0] CODE_RD     = 8'h10;
  localparam logic [7:0] CODE_SEQ_RD = 8'h14;
  localparam logic [7:0] CODE_NOP    = 8'h7F;
  localparam logic [7:0] RESP_FLAG   = 8'h80;
  localparam int         HDR_LEN     = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WDATA,
    ST_WBUS,
    ST_RBUS,
    ST_RSEND,
    ST_RESP
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic hdrStart;
    logic hdrLoad;
    logic wordShift;
    logic wordCapture;
    logic wordCntInc;
    logic addrStep;
    logic byteIdxInc;
    logic byteIdxClr;
    logic respSel;
  } ctrl_t;

endpackage

// File: rtl/ptt_datapath.sv
module ptt_datapath
  import ptt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctl,
  input  logic [7:0]          inData,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [2:0]          hdrCnt,
  output logic [$clog2(DATA_W/8)-1:0] byteIdx,
  output logic                isWrite,
  output logic                isRead,
  output logic                atLimit,
  output logic                firstWord,
  output logic                lastReadWord,
  output logic                readWordsZero,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busWdata,
  output logic [7:0]          outByte
);

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int MAX_WORDS = MAX_BYTES / LANES;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);

  logic [7:0]        codeReg;
  logic [15:0]       sizeReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wordReg;
  logic [CNT_W-1:0]  wordCnt;
  logic              isSeq;
  logic [15:0]       clampBytes;
  logic [15:0]       readWords;
  logic [15:0]       respCnt;
  logic [7:0]        laneBytes [LANES];

  assign isWrite = (codeReg == CODE_WR) || (codeReg == CODE_SEQ_WR);
  assign isRead  = (codeReg == CODE_RD) || (codeReg == CODE_SEQ_RD);
  assign isSeq   = (codeReg == CODE_SEQ_WR) || (codeReg == CODE_SEQ_RD);

  assign clampBytes    = (sizeReg > 16'(MAX_BYTES)) ? 16'(MAX_BYTES) : sizeReg;
  assign readWords     = clampBytes >> LANE_W;
  assign readWordsZero = (readWords == 16'd0);
  assign lastReadWord  = (16'(wordCnt) == readWords);
  assign firstWord     = (wordCnt == CNT_W'(1));
  assign atLimit       = (wordCnt == CNT_W'(MAX_WORDS));
  assign respCnt       = isWrite ? 16'(wordCnt) << LANE_W : 16'd0;

  assign busAddr  = addrReg;
  assign busWdata = wordReg;

  // header, address and word registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg <= '0;
      sizeReg <= '0;
      addrReg <= '0;
      hdrCnt  <= '0;
    end else if (ctl.hdrStart) begin
      codeReg <= inData;
      sizeReg <= '0;
      addrReg <= '0;
      hdrCnt  <= 3'd1;
    end else begin
      if (ctl.hdrLoad) begin
        hdrCnt <= hdrCnt + 3'd1;
        if (hdrCnt == 3'd2)      sizeReg[15:8] <= inData;
        else if (hdrCnt == 3'd3) sizeReg[7:0]  <= inData;
        else if (hdrCnt >= 3'd4) addrReg <= {addrReg[ADDR_W-9:0], inData};
      end
      if (ctl.addrStep && isSeq) addrReg <= addrReg + ADDR_W'(LANES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg <= '0;
    end else if (ctl.wordCapture) begin
      wordReg <= busRdata;
    end else if (ctl.wordShift) begin
      wordReg <= {inData, wordReg[DATA_W-1:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.hdrStart) begin
      wordCnt <= '0;
    end else if (ctl.wordCntInc) begin
      wordCnt <= wordCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.hdrStart || ctl.byteIdxClr) begin
      byteIdx <= '0;
    end else if (ctl.byteIdxInc) begin
      byteIdx <= byteIdx + LANE_W'(1);
    end
  end

  // byte lanes of the data word, least significant first
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneBytes[g] = wordReg[g*8 +: 8];
  end

  always_comb begin
    outByte = laneBytes[byteIdx];
    if (ctl.respSel) begin
      case (byteIdx)
        LANE_W'(0): outByte = codeReg | RESP_FLAG;
        LANE_W'(1): outByte = 8'h00;
        LANE_W'(2): outByte = respCnt[15:8];
        default:    outByte = respCnt[7:0];
      endcase
    end
  end

  assert_cnt_cap_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CNT_W'(MAX_WORDS));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wordCntInc && !ctl.hdrStart |=> wordCnt == $past(wordCnt) + CNT_W'(1));

endmodule

// File: rtl/ptt_control.sv
module ptt_control
  import ptt_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic              outReady,
  input  logic              busWaitReq,
  input  logic [2:0]        hdrCnt,
  input  logic [LANE_W-1:0] byteIdx,
  input  logic              isWrite,
  input  logic              isRead,
  input  logic              atLimit,
  input  logic              firstWord,
  input  logic              lastReadWord,
  input  logic              readWordsZero,
  output ctrl_t             ctl,
  output logic              inReady,
  output logic              outValid,
  output logic              outSop,
  output logic              outEop,
  output logic              busRead,
  output logic              busWrite
);

  localparam logic [LANE_W-1:0] LAST_LANE = '1;

  state_t state, stateNext;
  logic   eopSeen, eopSeenNext;
  logic   inFire, outFire;

  assign inFire  = inValid && inReady;
  assign outFire = outValid && outReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      eopSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      eopSeen <= eopSeenNext;
    end
  end

  always_comb begin
    stateNext   = state;
    eopSeenNext = eopSeen;
    ctl         = '0;
    inReady     = 1'b0;
    outValid    = 1'b0;
    outSop      = 1'b0;
    outEop      = 1'b0;
    busRead     = 1'b0;
    busWrite    = 1'b0;
    case (state)
      ST_IDLE: begin
        inReady = 1'b1;
        if (inFire && inSop && !inEop) begin
          ctl.hdrStart = 1'b1;
          stateNext    = ST_HDR;
        end
      end
      ST_HDR: begin
        inReady = 1'b1;
        if (inFire) begin
          ctl.hdrLoad = 1'b1;
          if (hdrCnt == 3'(HDR_LEN - 1)) begin
            ctl.byteIdxClr = 1'b1;
            if (isWrite)             stateNext = inEop ? ST_RESP : ST_WDATA;
            else if (isRead)         stateNext = readWordsZero ? ST_RESP : ST_RBUS;
            else                     stateNext = ST_RESP;
          end else if (inEop) begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WDATA: begin
        inReady = 1'b1;
        if (inFire) begin
          ctl.byteIdxInc = 1'b1;
          ctl.wordShift  = !atLimit;
          if (byteIdx == LAST_LANE && !atLimit) begin
            eopSeenNext = inEop;
            stateNext   = ST_WBUS;
          end else if (inEop) begin
            ctl.byteIdxClr = 1'b1;
            stateNext      = ST_RESP;
          end
        end
      end
      ST_WBUS: begin
        busWrite = 1'b1;
        if (!busWaitReq) begin
          ctl.wordCntInc = 1'b1;
          ctl.addrStep   = 1'b1;
          stateNext      = eopSeen ? ST_RESP : ST_WDATA;
        end
      end
      ST_RBUS: begin
        busRead = 1'b1;
        if (!busWaitReq) begin
          ctl.wordCapture = 1'b1;
          ctl.wordCntInc  = 1'b1;
          ctl.addrStep    = 1'b1;
          ctl.byteIdxClr  = 1'b1;
          stateNext       = ST_RSEND;
        end
      end
      ST_RSEND: begin
        outValid = 1'b1;
        outSop   = firstWord && (byteIdx == '0);
        outEop   = lastReadWord && (byteIdx == LAST_LANE);
        if (outFire) begin
          ctl.byteIdxInc = 1'b1;
          if (byteIdx == LAST_LANE) stateNext = lastReadWord ? ST_IDLE : ST_RBUS;
        end
      end
      ST_RESP: begin
        outValid    = 1'b1;
        ctl.respSel = 1'b1;
        outSop      = (byteIdx == '0);
        outEop      = (byteIdx == LAST_LANE);
        if (outFire) begin
          ctl.byteIdxInc = 1'b1;
          if (byteIdx == LAST_LANE) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite || busRead) && busWaitReq |=> $stable(busWrite) && $stable(busRead));

  assert_single_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

  assert_frame_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    outEop && outFire |=> !outValid && inReady);

  assert_no_input_R12: assert property (@(posedge clk) disable iff (!rstN)
    busWrite && !busWaitReq && eopSeen |=> !inReady);

endmodule

// File: rtl/ptt_converter.sv
module ptt_converter
  import ptt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outData,
  output logic              outSop,
  output logic              outEop,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busWaitReq
);

  localparam int LANE_W = $clog2(DATA_W / 8);

  ctrl_t             ctl;
  logic [2:0]        hdrCnt;
  logic [LANE_W-1:0] byteIdx;
  logic              isWrite, isRead, atLimit, firstWord, lastReadWord, readWordsZero;

  ptt_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData), .busRdata(busRdata),
    .hdrCnt(hdrCnt), .byteIdx(byteIdx), .isWrite(isWrite), .isRead(isRead),
    .atLimit(atLimit), .firstWord(firstWord), .lastReadWord(lastReadWord),
    .readWordsZero(readWordsZero), .busAddr(busAddr), .busWdata(busWdata),
    .outByte(outData)
  );

  ptt_control #(.LANE_W(LANE_W)) u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .outReady(outReady), .busWaitReq(busWaitReq), .hdrCnt(hdrCnt),
    .byteIdx(byteIdx), .isWrite(isWrite), .isRead(isRead), .atLimit(atLimit),
    .firstWord(firstWord), .lastReadWord(lastReadWord),
    .readWordsZero(readWordsZero), .ctl(ctl), .inReady(inReady),
    .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .busRead(busRead), .busWrite(busWrite)
  );

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite || busRead) && busWaitReq |=> $stable(busAddr) && $stable(busWdata));

  assert_write_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> isWrite);

  assert_read_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> isRead);

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outSop) && $stable(outEop));

endmodule

// File: tb/ptt_converter_bench.sv
module ptt_converter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int RXB        = 4096;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [7:0]  code;
    logic [15:0] size;
    logic [31:0] addr;
    logic [15:0] nData;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h04, 16'd8,  32'h0000_0010, 16'd8},
    '{8'h14, 16'd8,  32'h0000_0010, 16'd0},
    '{8'h00, 16'd8,  32'h0000_0020, 16'd8},
    '{8'h10, 16'd8,  32'h0000_0020, 16'd0},
    '{8'h7F, 16'd0,  32'h0000_0000, 16'd0},
    '{8'h33, 16'd4,  32'h0000_0000, 16'd0},
    '{8'h14, 16'd2,  32'h0000_0030, 16'd0},
    '{8'h04, 16'd6,  32'h0000_0040, 16'd6}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inSop, inEop, inReady;
  logic [7:0]  inData;
  logic        outValid, outReady, outSop, outEop;
  logic [7:0]  outData;
  logic [31:0] busAddr, busWdata, busRdata;
  logic        busRead, busWrite, busWaitReq;

  int checks, failures;
  logic [31:0] slvMem   [MEM_WORDS];
  logic [31:0] modelMem [MEM_WORDS];
  logic [7:0]  expBuf   [RXB];
  logic [7:0]  rxBuf    [RXB];
  logic        rxSopB   [RXB];
  logic        rxEopB   [RXB];
  int rxCnt, pktCnt, accCnt, busHoldViol, outHoldViol, duplexViol;
  logic [15:0] lfsr;
  logic        pStallW, pStallR, pOutStall, pOutSop, pOutEop;
  logic [31:0] pAddr, pData;
  logic [7:0]  pOutData;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptt_converter u_ptt_converter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSop(inSop), .inEop(inEop), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outSop(outSop), .outEop(outEop),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .busWaitReq(busWaitReq)
  );

  // register-file slave with pseudo-random stalls and output back-pressure
  assign busRdata = slvMem[busAddr[7:2]];

  always @(posedge clk) begin
    if (!rstN) begin
      lfsr       <= 16'hACE1;
      busWaitReq <= 1'b0;
      outReady   <= 1'b1;
      accCnt     <= 0;
      for (int j = 0; j < MEM_WORDS; j++) slvMem[j] <= '0;
      pStallW <= 1'b0; pStallR <= 1'b0; pAddr <= '0; pData <= '0;
      busHoldViol <= 0;
    end else begin
      lfsr       <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busWaitReq <= lfsr[1] & lfsr[4];
      outReady   <= !(lfsr[2] & lfsr[7]);
      if (busWrite && !busWaitReq) slvMem[busAddr[7:2]] <= busWdata;
      if ((busWrite || busRead) && !busWaitReq) accCnt <= accCnt + 1;
      // R6: stalled command must be held unchanged
      if ((pStallW && !(busWrite && busAddr == pAddr && busWdata == pData)) ||
          (pStallR && !(busRead && busAddr == pAddr)))
        busHoldViol <= busHoldViol + 1;
      pStallW <= busWrite && busWaitReq;
      pStallR <= busRead && busWaitReq;
      pAddr   <= busAddr;
      pData   <= busWdata;
    end
  end

  // response capture; handshake fires at the following rising edge
  always @(negedge clk) begin
    if (!rstN) begin
      rxCnt <= 0; pktCnt <= 0; outHoldViol <= 0; duplexViol <= 0;
      pOutStall <= 1'b0; pOutData <= '0; pOutSop <= 1'b0; pOutEop <= 1'b0;
    end else begin
      if (outValid && outReady) begin
        rxBuf[rxCnt % RXB]  <= outData;
        rxSopB[rxCnt % RXB] <= outSop;
        rxEopB[rxCnt % RXB] <= outEop;
        rxCnt <= rxCnt + 1;
        if (outEop) pktCnt <= pktCnt + 1;
      end
      if (pOutStall && !(outValid && outData == pOutData && outSop == pOutSop && outEop == pOutEop))
        outHoldViol <= outHoldViol + 1;
      if (inReady && outValid) duplexViol <= duplexViol + 1;
      pOutStall <= outValid && !outReady;
      pOutData  <= outData;
      pOutSop   <= outSop;
      pOutEop   <= outEop;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dByte(input int seed, input int k);
    return 8'((seed * 37 + k * 13 + 5) & 255);
  endfunction

  task automatic sendByte(input logic [7:0] d, input logic s, input logic e);
    inValid = 1'b1; inData = d; inSop = s; inEop = e;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  // R2: code, reserved, size MSB first, address MSB first
  task automatic sendHeader(input logic [7:0] code, input logic [15:0] size,
                            input logic [31:0] addr, input bit last);
    logic [7:0] hb [8];
    hb[0] = code; hb[1] = 8'h5A; hb[2] = size[15:8]; hb[3] = size[7:0];
    hb[4] = addr[31:24]; hb[5] = addr[23:16]; hb[6] = addr[15:8]; hb[7] = addr[7:0];
    for (int i = 0; i < 8; i++) sendByte(hb[i], i == 0, last && i == 7);
  endtask

  task automatic runVec(input logic [7:0] code, input logic [15:0] size,
                        input logic [31:0] addr, input int nData, input int seed,
                        input string tag);
    int expLen, expAcc, startRx, startAcc, startPkt, bad, memBad, words, cnt;
    logic [31:0] a, w;
    bit framingOk;
    expLen = 0; expAcc = 0; a = addr;
    if (code == 8'h00 || code == 8'h04) begin
      words = nData / 4;
      if (words > 256) words = 256;
      for (int i = 0; i < words; i++) begin
        w = {dByte(seed, 4*i+3), dByte(seed, 4*i+2), dByte(seed, 4*i+1), dByte(seed, 4*i)};
        modelMem[a[7:2]] = w;
        if (code == 8'h04) a = a + 4;
      end
      cnt = words * 4; expAcc = words;
      expBuf[0] = code | 8'h80; expBuf[1] = 8'h00;
      expBuf[2] = 8'(cnt >> 8); expBuf[3] = 8'(cnt); expLen = 4;
    end else if ((code == 8'h10 || code == 8'h14) && ((size > 1024 ? 1024 : size) / 4) > 0) begin
      words = (size > 1024 ? 1024 : int'(size)) / 4;
      for (int i = 0; i < words; i++) begin
        w = modelMem[a[7:2]];
        for (int b = 0; b < 4; b++) expBuf[4*i+b] = w[8*b +: 8];
        if (code == 8'h14) a = a + 4;
      end
      expLen = words * 4; expAcc = words;
    end else begin
      expBuf[0] = code | 8'h80; expBuf[1] = 8'h00; expBuf[2] = 8'h00; expBuf[3] = 8'h00;
      expLen = 4;
    end
    startRx = rxCnt; startAcc = accCnt; startPkt = pktCnt;
    sendHeader(code, size, addr, nData == 0);
    for (int k = 0; k < nData; k++) sendByte(dByte(seed, k), 1'b0, k == nData - 1);
    while (pktCnt == startPkt) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(rxCnt - startRx == expLen, tag, "response length", rxCnt - startRx, expLen);
    bad = 0; framingOk = 1'b1;
    for (int i = 0; i < expLen; i++) begin
      if (rxBuf[(startRx + i) % RXB] !== expBuf[i]) bad++;
      if (rxSopB[(startRx + i) % RXB] !== (i == 0)) framingOk = 1'b0;
      if (rxEopB[(startRx + i) % RXB] !== (i == expLen - 1)) framingOk = 1'b0;
    end
    chk(bad == 0, tag, "response bytes mismatching", bad, 0);
    chk(framingOk, tag, "start/end flags", framingOk, 1);
    chk(accCnt - startAcc == expAcc, tag, "bus accesses", accCnt - startAcc, expAcc);
    memBad = 0;
    for (int j = 0; j < MEM_WORDS; j++) if (slvMem[j] !== modelMem[j]) memBad++;
    chk(memBad == 0, tag, "register file words differing", memBad, 0);
  endtask

  function automatic string vecTag(input int v);
    case (v)
      0: return "R2 R3 R4";
      1: return "R5";
      2: return "R3 R4";
      3: return "R5";
      4: return "R7";
      5: return "R7";
      6: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic runAll();
    int startRx, startAcc;
    // R1: reset state
    chk(inReady === 1'b1, "R1", "inReady after reset", inReady, 1);
    chk(outValid === 1'b0, "R1", "outValid after reset", outValid, 0);
    chk(busRead === 1'b0 && busWrite === 1'b0, "R1", "bus idle after reset",
        {busRead, busWrite}, 0);
    for (int v = 0; v < NVEC; v++)
      runVec(VECS[v].code, VECS[v].size, VECS[v].addr, int'(VECS[v].nData), v + 1, vecTag(v));
    // R10: truncated header and stray bytes
    startRx = rxCnt; startAcc = accCnt;
    sendByte(8'h04, 1'b1, 1'b0);
    sendByte(8'h00, 1'b0, 1'b0);
    sendByte(8'h00, 1'b0, 1'b1);
    sendByte(8'h10, 1'b0, 1'b0);
    sendByte(8'h00, 1'b0, 1'b1);
    repeat (40) @(negedge clk);
    chk(rxCnt == startRx, "R10", "bytes answered to broken packet", rxCnt - startRx, 0);
    chk(accCnt == startAcc, "R10", "bus accesses from broken packet", accCnt - startAcc, 0);
    runVec(8'h14, 16'd16, 32'h0000_0010, 0, 20, "R10 R5");
    // R8: oversize write and read
    runVec(8'h04, 16'd1028, 32'h0000_0000, 1028, 30, "R8");
    runVec(8'h10, 16'h0800, 32'h0000_0008, 0, 31, "R8");
    chk(busHoldViol == 0, "R6", "stalled command changes", busHoldViol, 0);
    chk(outHoldViol == 0, "R12", "stalled output changes", outHoldViol, 0);
    chk(duplexViol == 0, "R12", "input and output active together", duplexViol, 0);
  endtask

  initial begin
    bit timedOut;
    checks = 0; failures = 0; timedOut = 1'b0;
    rstN = 1'b0; inValid = 1'b0; inData = '0; inSop = 1'b0; inEop = 1'b0;
    for (int j = 0; j < MEM_WORDS; j++) modelMem[j] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule